// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit runs the four single-bit operations of an integer core on a 32-bit operand: test, set, clear and complement. The operand is either a register value supplied with the request or a word in memory. The bit number comes either from a register offset operand or from an immediate. Every operation returns the original value of the chosen bit as the carry flag. The modifying operations also produce a new operand value. For register operands this value goes back through a register write port. For memory operands it goes back through a write on the memory port.

When the operand is in memory and the bit number comes from a register, the offset is treated as a signed bit distance from the base address. Its upper bits choose a word that may lie below or above the base word, and its low five bits choose the bit within that word. An immediate bit number only chooses a bit within the base word. The final address is ANDed with an address-size mask before it is issued. A test on memory performs a read only. The modifying operations perform a read followed by a write to the same address. The unit serves one request at a time and ignores new requests while it is busy.

Top module: `bit_modify_unit`

## Requirements
- R1: Every operation sets `cf_o` to the value the selected bit had before the operation. The operation code on `op_i` is 0 for test, 1 for set, 2 for clear and 3 for complement.
- R2: Set forces the selected bit to 1, clear forces it to 0, and complement inverts it. All other bits keep their value, and test changes no bit.
- R3: With `mem_form_i`=0, the bit number is `offs_i[4:0]` (or the immediate, see R5). `done_o` pulses in the cycle after `start_i`. For set, clear and complement, `reg_we_o` is 1 with `reg_wdata_o` holding the modified value.
- R4: A register-form test raises `done_o` with `reg_we_o` at 0.
- R5: With `imm_form_i`=1, the bit number is `imm_i[4:0]` and the upper immediate bits are ignored. A memory access then goes to `base_i & amask_i`, regardless of `offs_i`.
- R6: With `mem_form_i`=1 and `imm_form_i`=0, the access address is `(base_i + 4*floor(offs_i/32)) & amask_i`, where `offs_i` is signed.
- R7: A memory test issues exactly one read (`mem_we_o`=0) and no write.
- R8: A memory set, clear or complement issues one read and then one write to the same address, carrying the modified word.
- R9: `busy_o` is high from an accepted memory request until its final acknowledge. While it is high, `start_i` is ignored. An outstanding memory request keeps its address and direction until it is acknowledged.
- R10: After reset, `busy_o`, `done_o`, `cf_o` and `mem_req_o` are 0. `cf_o` changes only in a cycle where `done_o` is 1, and for memory operations this happens only after the final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted when not busy |
| op_i | input | 2 | Operation code: 0 test, 1 set, 2 clear, 3 complement |
| mem_form_i | input | 1 | 1 = operand in memory, 0 = register operand |
| imm_form_i | input | 1 | 1 = bit number from immediate |
| reg_val_i | input | 32 | Register operand value |
| offs_i | input | 32 | Register bit offset (signed in memory form) |
| imm_i | input | 8 | Immediate bit number |
| base_i | input | 32 | Base byte address of the memory operand |
| amask_i | input | 32 | Address-size mask |
| busy_o | output | 1 | Memory operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cf_o | output | 1 | Carry flag: original selected bit |
| reg_we_o | output | 1 | Register write-back enable |
| reg_wdata_o | output | 32 | Register write-back value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |

## Verification
A corrupted latched bit number or operation shows up as a write word that differs from the read word in the wrong bit, or in more than one bit. It also gives the wrong carry at the `done_o` pulse of that same operation. A wrong address register shows on `mem_addr_o` during the read cycle, before any acknowledge, and a read and write that disagree on the address show during the write request. A state machine that skips or repeats a phase gives a read or write count other than expected, or a missing or extra `done_o`. A `cf_o` that moves outside a completion cycle shows up within one clock.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [1:0] {
    BOP_TEST = 2'd0,
    BOP_SET  = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_FLIP = 2'd3
  } bop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } bst_e;
endpackage

// File: rtl/bmu_addr_gen.sv
// Bit number selection and word address computation.
module bmu_addr_gen #(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int IMMW = 8,
  localparam int IDXW = $clog2(DW),
  localparam int BSH  = $clog2(DW / 8)
) (
  input  logic            imm_form_i,
  input  logic [DW-1:0]   offs_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   amask_i,
  output logic [IDXW-1:0] idx_o,
  output logic [AW-1:0]   addr_o
);
  logic signed [DW-1:0] word_disp;
  logic [AW+DW-1:0]     disp_ext;
  logic [AW-1:0]        byte_off;
  logic                 unused_imm_hi;

  // floor(offs / DW) is an arithmetic shift right
  assign word_disp = $signed(offs_i) >>> IDXW;
  assign disp_ext  = {{AW{word_disp[DW-1]}}, word_disp};
  assign byte_off  = disp_ext[AW-1:0] << BSH;

  assign idx_o  = imm_form_i ? imm_i[IDXW-1:0] : offs_i[IDXW-1:0];
  assign addr_o = (base_i + (imm_form_i ? '0 : byte_off)) & amask_i;

  assign unused_imm_hi = ^imm_i[IMMW-1:IDXW];
endmodule

// File: rtl/bmu_bit_alu.sv
// Per-bit set/clear/complement with original bit extraction.
module bmu_bit_alu
  import bmu_pkg::*;
#(
  parameter int DW = 32,
  localparam int IDXW = $clog2(DW)
) (
  input  bop_e            op_i,
  input  logic [DW-1:0]   val_i,
  input  logic [IDXW-1:0] idx_i,
  output logic            orig_o,
  output logic [DW-1:0]   res_o
);
  assign orig_o = val_i[idx_i];

  for (genvar g = 0; g < DW; g++) begin : g_bit
    logic hit;
    assign hit = (idx_i == IDXW'(g));
    assign res_o[g] = !hit                ? val_i[g] :
                      (op_i == BOP_SET)   ? 1'b1     :
                      (op_i == BOP_CLR)   ? 1'b0     :
                      (op_i == BOP_FLIP)  ? ~val_i[g] :
                                            val_i[g];
  end
endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
  import bmu_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int IMMW = 8,
  localparam int IDXW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic            mem_form_i,
  input  logic            imm_form_i,
  input  logic [DW-1:0]   reg_val_i,
  input  logic [DW-1:0]   offs_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   amask_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            cf_o,
  output logic            reg_we_o,
  output logic [DW-1:0]   reg_wdata_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [DW-1:0]   mem_rdata_i
);
  bst_e            st_q, st_d;
  bop_e            op_q, op_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [DW-1:0]   wdata_q, wdata_d;
  logic            orig_q, orig_d;
  logic            done_q, done_d;
  logic            cf_q, cf_d;
  logic            rwe_q, rwe_d;
  logic [DW-1:0]   rwd_q, rwd_d;

  logic [IDXW-1:0] idx_now;
  logic [AW-1:0]   addr_now;
  bop_e            op_in;
  bop_e            alu_op;
  logic [DW-1:0]   alu_val;
  logic [IDXW-1:0] alu_idx;
  logic            alu_orig;
  logic [DW-1:0]   alu_res;
  logic            idle;

  assign op_in = bop_e'(op_i);
  assign idle  = (st_q == ST_IDLE);

  bmu_addr_gen #(.DW(DW), .AW(AW), .IMMW(IMMW)) u_agen (
    .imm_form_i (imm_form_i),
    .offs_i     (offs_i),
    .imm_i      (imm_i),
    .base_i     (base_i),
    .amask_i    (amask_i),
    .idx_o      (idx_now),
    .addr_o     (addr_now)
  );

  // idle: operate on the register operand; otherwise on returned data
  assign alu_op  = idle ? op_in     : op_q;
  assign alu_val = idle ? reg_val_i : mem_rdata_i;
  assign alu_idx = idle ? idx_now   : idx_q;

  bmu_bit_alu #(.DW(DW)) u_alu (
    .op_i   (alu_op),
    .val_i  (alu_val),
    .idx_i  (alu_idx),
    .orig_o (alu_orig),
    .res_o  (alu_res)
  );

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    idx_d   = idx_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    orig_d  = orig_q;
    done_d  = 1'b0;
    cf_d    = cf_q;
    rwe_d   = 1'b0;
    rwd_d   = rwd_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          op_d   = op_in;
          idx_d  = idx_now;
          addr_d = addr_now;
          if (mem_form_i) begin
            st_d = ST_RD;
          end else begin
            done_d = 1'b1;
            cf_d   = alu_orig;
            rwe_d  = (op_in != BOP_TEST);
            rwd_d  = alu_res;
          end
        end
      end
      ST_RD: begin
        if (mem_ack_i) begin
          orig_d  = alu_orig;
          wdata_d = alu_res;
          if (op_q == BOP_TEST) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            cf_d   = alu_orig;
          end else begin
            st_d = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (mem_ack_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          cf_d   = orig_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= BOP_TEST;
      idx_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      orig_q  <= 1'b0;
      done_q  <= 1'b0;
      cf_q    <= 1'b0;
      rwe_q   <= 1'b0;
      rwd_q   <= '0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      orig_q  <= orig_d;
      done_q  <= done_d;
      cf_q    <= cf_d;
      rwe_q   <= rwe_d;
      rwd_q   <= rwd_d;
    end
  end

  assign busy_o      = !idle;
  assign done_o      = done_q;
  assign cf_o        = cf_q;
  assign reg_we_o    = rwe_q;
  assign reg_wdata_o = rwd_q;
  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic          cf_o,
  input logic          reg_we_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic [DW-1:0] mem_rdata_i
);
  logic [AW-1:0] rd_addr_seen;
  logic [DW-1:0] rd_data_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_seen <= '0;
      rd_data_seen <= '0;
    end else if (mem_req_o && !mem_we_o && mem_ack_i) begin
      rd_addr_seen <= mem_addr_o;
      rd_data_seen <= mem_rdata_i;
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  p_cf_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cf_o) |-> done_o);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_wr_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> $past(mem_req_o && !mem_we_o && mem_ack_i));

  p_wr_same_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> mem_addr_o == rd_addr_seen);

  p_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> $countones(mem_wdata_o ^ rd_data_seen) <= 1);

  p_regwe_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> done_o);
endmodule

bind bit_modify_unit bmu_checker #(.DW(DW), .AW(AW)) u_bmu_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cf_o        (cf_o),
  .reg_we_o    (reg_we_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/tb_bit_modify_unit.sv
`timescale 1ns/1ps
module tb_bit_modify_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic        mem_form_i = 1'b0;
  logic        imm_form_i = 1'b0;
  logic [31:0] reg_val_i = '0;
  logic [31:0] offs_i = '0;
  logic [7:0]  imm_i = '0;
  logic [31:0] base_i = '0;
  logic [31:0] amask_i = '1;
  logic        busy_o, done_o, cf_o, reg_we_o, mem_req_o, mem_we_o;
  logic [31:0] reg_wdata_o, mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #10 clk = ~clk;

  bit_modify_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .mem_form_i(mem_form_i), .imm_form_i(imm_form_i), .reg_val_i(reg_val_i),
    .offs_i(offs_i), .imm_i(imm_i), .base_i(base_i), .amask_i(amask_i),
    .busy_o(busy_o), .done_o(done_o), .cf_o(cf_o), .reg_we_o(reg_we_o),
    .reg_wdata_o(reg_wdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  typedef struct {
    bit          memf;
    logic [1:0]  op;
    logic [31:0] addr;
    logic        cf;
    logic [31:0] res;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  int          lat = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          extra_done = 0;
  logic [31:0] rd_addr = '0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        held_cf = 1'b0;
  bit          finished = 0;

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0F0F5A5A;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: ack after lat idle cycles
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
      end else if (mem_req_o) begin
        if (wait_cnt >= lat) begin
          wait_cnt = 0;
          mem_ack_i = 1'b1;
          if (mem_we_o) begin
            wr_cnt++;
            wr_addr = mem_addr_o;
            wr_data = mem_wdata_o;
          end else begin
            rd_cnt++;
            rd_addr = mem_addr_o;
            mem_rdata_i = mdata(mem_addr_o);
          end
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && busy_o) check("R10 cf held while busy", {31'd0, cf_o}, {31'd0, held_cf});
      if (rst_n && done_o) begin
        if (sb.size() == 0) begin
          extra_done++;
          total++; bad++;
          $display("FAIL R9 unexpected done actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check("R1 carry", {31'd0, cf_o}, {31'd0, e.cf});
          held_cf = e.cf;
          if (!e.memf) begin
            check("R3/R4 reg_we", {31'd0, reg_we_o}, {31'd0, (e.op != 2'd0)});
            if (e.op != 2'd0) check("R2 R3 reg result", reg_wdata_o, e.res);
          end else begin
            check("R4 reg_we in mem form", {31'd0, reg_we_o}, 32'd0);
            check("R7 R8 read count", rd_cnt, 1);
            check("R5 R6 read address", rd_addr, e.addr);
            check("R7 R8 write count", wr_cnt, (e.op != 2'd0) ? 1 : 0);
            if (e.op != 2'd0) begin
              check("R8 write address", wr_addr, e.addr);
              check("R2 R8 write data", wr_data, e.res);
            end
          end
          rd_cnt = 0;
          wr_cnt = 0;
        end
      end
    end
  end

  task automatic issue(input logic [1:0] op, input bit memf, input bit immf,
                       input logic [31:0] rv, input logic [31:0] offs,
                       input logic [7:0] imm, input logic [31:0] base,
                       input logic [31:0] mask, input int l, input bit poke);
    exp_t e;
    logic [4:0]  idx;
    logic [31:0] addr, val;
    idx  = immf ? imm[4:0] : offs[4:0];
    addr = immf ? (base & mask)
                : ((base + (32'($signed(offs) >>> 5) << 2)) & mask);
    val  = memf ? mdata(addr) : rv;
    e.memf = memf; e.op = op; e.addr = addr; e.cf = val[idx];
    e.res = val;
    case (op)
      2'd1: e.res[idx] = 1'b1;
      2'd2: e.res[idx] = 1'b0;
      2'd3: e.res[idx] = ~val[idx];
      default: ;
    endcase
    lat = l;
    sb.push_back(e);
    start_i = 1'b1; op_i = op; mem_form_i = memf; imm_form_i = immf;
    reg_val_i = rv; offs_i = offs; imm_i = imm; base_i = base; amask_i = mask;
    @(negedge clk);
    start_i = 1'b0;
    if (memf) check("R9 busy after accept", {31'd0, busy_o}, 32'd1);
    if (poke) begin
      // intruding register request while busy must be ignored
      start_i = 1'b1; mem_form_i = 1'b0; op_i = 2'd1; reg_val_i = 32'h0;
      offs_i = 32'd7;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    op_i = 2'd0; offs_i = 32'hDEAD_BEEF; base_i = 32'h1357_9BDF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset busy", {31'd0, busy_o}, 32'd0);
    check("R10 reset done", {31'd0, done_o}, 32'd0);
    check("R10 reset cf", {31'd0, cf_o}, 32'd0);
    check("R10 reset req", {31'd0, mem_req_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // register forms (R3, R4): offset high bits ignored
    issue(2'd0, 0, 0, 32'h0000_0020, 32'hFFFF_FFE5, 8'd0, 0, '1, 0, 0);
    issue(2'd1, 0, 0, 32'h1234_0000, 32'h0000_0043, 8'd0, 0, '1, 0, 0);
    issue(2'd2, 0, 0, 32'hFFFF_FFFF, 32'h8000_001F, 8'd0, 0, '1, 0, 0);
    issue(2'd3, 0, 0, 32'hA5A5_A5A5, 32'd0, 8'd0, 0, '1, 0, 0);
    issue(2'd3, 0, 0, 32'hA5A5_A5A5, 32'd1, 8'd0, 0, '1, 0, 0);
    // immediate register form (R5): upper immediate bits ignored
    issue(2'd1, 0, 1, 32'h0, 32'd3, 8'hFF, 0, '1, 0, 0);
    // memory, immediate bit number (R5): offset does not move address
    issue(2'd0, 1, 1, 0, 32'h0000_4000, 8'hE9, 32'h0000_1000, '1, 1, 0);
    issue(2'd3, 1, 1, 0, 32'hFFFF_0000, 8'd31, 32'h0000_2004, '1, 0, 0);
    // memory, signed register offset (R6)
    issue(2'd1, 1, 0, 0, 32'd100, 8'd0, 32'h0000_8000, '1, 2, 0);
    issue(2'd2, 1, 0, 0, 32'hFFFF_FFFF, 8'd0, 32'h0000_8000, '1, 0, 0);
    issue(2'd3, 1, 0, 0, 32'hFFFF_FFDF, 8'd0, 32'h0000_8000, '1, 1, 0);
    issue(2'd0, 1, 0, 0, 32'h7FFF_FFE0, 8'd0, 32'h0000_0010, '1, 0, 0);
    // address-size mask (R6)
    issue(2'd1, 1, 0, 0, 32'h0000_0400, 8'd0, 32'hABCD_FFF0, 32'h0000_FFFF, 1, 0);
    issue(2'd0, 1, 1, 0, 32'd0, 8'd2, 32'hFEDC_1234, 32'h0000_FFFF, 0, 0);
    // start while busy ignored (R9)
    issue(2'd2, 1, 0, 0, 32'd64, 8'd0, 32'h0000_3000, '1, 3, 1);
    repeat (5) @(negedge clk);
    check("R9 no done from ignored start", extra_done, 0);
    check("R9 idle after op", {31'd0, busy_o}, 32'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule